// File: doc/BRIEF.md
# Selectable Arithmetic Logic Shift Unit

This block is a purely combinational datapath slice that computes one of fourteen operations on two W-bit operands, W being 16 by default. A 4-bit operation select and a carry input choose the operation. The result and a carry output settle in the same cycle the inputs are applied, so the block can sit directly in front of an accumulator register.

The upper two select bits choose which source drives the result: the arithmetic stage, the logic stage, a right shift of A or a left shift of A.

For arithmetic, the lower two select bits choose what the adder adds to A: zero, B, the inverse of B, or all ones. The carry input is then added on top. One adder therefore covers these operations:

- transfer
- increment
- add
- add with carry
- subtract with borrow
- subtract
- decrement

For logic, the lower two select bits choose AND, OR, XOR, or the complement of A.

Top module: `alsu_top`

## Requirements
- R1: sel[3:2] picks the result source: 00 arithmetic, 01 logic, 10 shift right of opA, 11 shift left of opA. For the shift codes, sel[1:0] and carryIn have no effect on result or carryOut.
- R2: With sel[3:2]=00, the code {sel[1:0],carryIn} gives these results, modulo 2^W: 000 gives opA, 001 gives opA+1, 010 gives opA+opB, and 011 gives opA+opB+1.
- R3: With sel[3:2]=00, the code {sel[1:0],carryIn} gives these results, modulo 2^W: 100 gives opA+~opB, 101 gives opA+~opB+1 (opA-opB), 110 gives opA-1, and 111 gives opA.
- R4: For arithmetic codes, carryOut is bit W of the (W+1)-bit sum of opA, the B-side operand and carryIn. The B-side operand is 0, opB, ~opB or all ones for sel[1:0] = 00, 01, 10, 11. So opA=all ones with increment gives 0 with carryOut 1, and equal operands with subtract give 0 with carryOut 1.
- R5: With sel[3:2]=01, sel[1:0] gives these results: 00 opA&opB, 01 opA|opB, 10 opA^opB, 11 ~opA. carryIn has no effect.
- R6: Shift right sets result[i]=opA[i+1] and result[W-1]=0.
- R7: Shift left sets result[i]=opA[i-1] and result[0]=0.
- R8: carryOut is 0 for every logic and shift code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | W | First operand; the only operand of shifts and complement |
| opB | input | W | Second operand |
| sel | input | 4 | Operation select; bits 3:2 choose the source, bits 1:0 the variant |
| carryIn | input | 1 | Carry into the adder; used only by arithmetic codes |
| result | output | W | Operation result |
| carryOut | output | 1 | Adder carry-out for arithmetic codes, else 0 |

## Verification
The adder always computes, and its carry can come up in the same cycle that a logic or shift code is selected. The bench provokes this with operands that produce a full-width carry, such as all ones plus all ones, applied under every logic and shift code with carryIn at 1. It judges the case by requiring carryOut to be 0 and the result to match the chosen source. A second overlap is between carryIn and the all-ones B operand: it is exercised by applying opA=0 under code 110 and code 111. Those two codes must give all ones with no carry, and opA with a carry, respectively.

// File: rtl/alsu_pkg.sv
package alsu_pkg;
  typedef enum logic [1:0] {
    SRC_ARITH = 2'b00,
    SRC_LOGIC = 2'b01,
    SRC_SHR   = 2'b10,
    SRC_SHL   = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    BSEL_ZERO = 2'b00,
    BSEL_PASS = 2'b01,
    BSEL_INV  = 2'b10,
    BSEL_ONES = 2'b11
  } bsel_e;

  typedef enum logic [1:0] {
    LOP_AND  = 2'b00,
    LOP_OR   = 2'b01,
    LOP_XOR  = 2'b10,
    LOP_NOTA = 2'b11
  } lop_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    src_e  src;
    bsel_e bSel;
    lop_e  lop;
    logic  addCin;
    logic  carryKeep;
  } strobes_t;
endpackage

// File: rtl/alsu_ctrl.sv
module alsu_ctrl
  import alsu_pkg::*;
(
  input  logic [3:0] sel,
  input  logic       carryIn,
  output strobes_t   strobes
);
  always_comb begin
    strobes.src       = src_e'(sel[3:2]);
    strobes.bSel      = bsel_e'(sel[1:0]);
    strobes.lop       = lop_e'(sel[1:0]);
    strobes.addCin    = carryIn & (sel[3:2] == 2'b00);
    strobes.carryKeep = (sel[3:2] == 2'b00);
  end
endmodule

// File: rtl/alsu_dp.sv
module alsu_dp
  import alsu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  strobes_t     strobes,
  output logic [W-1:0] result,
  output logic         carryOut
);
  logic [W:0] carry;
  assign carry[0] = strobes.addCin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bIn, sumBit, logBit, shrBit, shlBit;

    // B-side adder input
    always_comb begin
      case (strobes.bSel)
        BSEL_ZERO: bIn = 1'b0;
        BSEL_PASS: bIn = opB[i];
        BSEL_INV:  bIn = ~opB[i];
        default:   bIn = 1'b1;
      endcase
    end

    // Full-adder cell of the ripple chain
    assign sumBit     = opA[i] ^ bIn ^ carry[i];
    assign carry[i+1] = (opA[i] & bIn) | (carry[i] & (opA[i] ^ bIn));

    // Logic cell
    always_comb begin
      case (strobes.lop)
        LOP_AND: logBit = opA[i] & opB[i];
        LOP_OR:  logBit = opA[i] | opB[i];
        LOP_XOR: logBit = opA[i] ^ opB[i];
        default: logBit = ~opA[i];
      endcase
    end

    // Shift routing with zero fill at the vacated end
    if (i == W - 1) begin : g_shrTop
      assign shrBit = 1'b0;
    end else begin : g_shrMid
      assign shrBit = opA[i+1];
    end
    if (i == 0) begin : g_shlBot
      assign shlBit = 1'b0;
    end else begin : g_shlMid
      assign shlBit = opA[i-1];
    end

    // 4-to-1 source select
    always_comb begin
      case (strobes.src)
        SRC_ARITH: result[i] = sumBit;
        SRC_LOGIC: result[i] = logBit;
        SRC_SHR:   result[i] = shrBit;
        default:   result[i] = shlBit;
      endcase
    end
  end

  assign carryOut = strobes.carryKeep & carry[W];
endmodule

// File: rtl/alsu_top.sv
module alsu_top
  import alsu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [3:0]   sel,
  input  logic         carryIn,
  output logic [W-1:0] result,
  output logic         carryOut
);
  strobes_t strobes;

  alsu_ctrl u_ctrl (
    .sel     (sel),
    .carryIn (carryIn),
    .strobes (strobes)
  );

  alsu_dp #(.W(W)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .result   (result),
    .carryOut (carryOut)
  );
endmodule

// File: rtl/alsu_checker.sv
module alsu_checker #(
  parameter int W = 16
) (
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic [3:0]   sel,
  input logic         carryIn,
  input logic [W-1:0] result,
  input logic         carryOut
);
  logic [W:0] addSum;
  assign addSum = {1'b0, opA} + {1'b0, opB} + {{W{1'b0}}, carryIn};

  always_comb begin
    if (sel[3:2] == 2'b10)
      assert_shr_R6: assert (result == (opA >> 1));
    if (sel[3:2] == 2'b11)
      assert_shl_R7: assert (result == (opA << 1));
    if (sel[3:2] != 2'b00)
      assert_no_carry_R8: assert (carryOut == 1'b0);
    if (sel == 4'b0100)
      assert_and_R5: assert (result == (opA & opB));
    if (sel == 4'b0001)
      assert_add_R4: assert ({carryOut, result} == addSum);
  end
endmodule

bind alsu_top alsu_checker #(.W(W)) u_chk (
  .opA      (opA),
  .opB      (opB),
  .sel      (sel),
  .carryIn  (carryIn),
  .result   (result),
  .carryOut (carryOut)
);

// File: tb/alsu_top_tb.sv
module alsu_top_tb;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [W-1:0] opA, opB, result;
  logic [3:0]   sel;
  logic         carryIn, carryOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  alsu_top #(.W(W)) u_dut (
    .opA(opA), .opB(opB), .sel(sel), .carryIn(carryIn),
    .result(result), .carryOut(carryOut)
  );

  function automatic logic [W:0] refModel(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic [3:0] s, input logic c);
    logic [W-1:0] bb;
    case (s[3:2])
      2'b00: begin
        case (s[1:0])
          2'b00:   bb = '0;
          2'b01:   bb = b;
          2'b10:   bb = ~b;
          default: bb = '1;
        endcase
        return {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, c};
      end
      2'b01: begin
        case (s[1:0])
          2'b00:   return {1'b0, a & b};
          2'b01:   return {1'b0, a | b};
          2'b10:   return {1'b0, a ^ b};
          default: return {1'b0, ~a};
        endcase
      end
      2'b10:   return {2'b00, a[W-1:1]};
      default: return {1'b0, a[W-2:0], 1'b0};
    endcase
  endfunction

  task automatic applyCheck(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic [3:0] s, input logic c,
                            input logic [W:0] expd, input string req);
    @(posedge clk);
    opA = a; opB = b; sel = s; carryIn = c;
    @(negedge clk);
    checks++;
    if ({carryOut, result} !== expd) begin
      fails++;
      $display("FAIL %s sel=%b cin=%b a=%h b=%h actual=%h expected=%h",
               req, s, c, a, b, {carryOut, result}, expd);
    end
  endtask

  task automatic testIdle();
    applyCheck('0, '0, 4'b0000, 1'b0, '0, "R1 idle");
  endtask

  task automatic testSweep();
    for (int rep = 0; rep < 40; rep++) begin
      for (int code = 0; code < 32; code++) begin
        logic [W-1:0] a, b;
        a = W'($urandom);
        b = W'($urandom);
        applyCheck(a, b, 4'(code >> 1), code[0],
                   refModel(a, b, 4'(code >> 1), code[0]), "R2 R3 R5 sweep");
      end
    end
  endtask

  task automatic testArithEdges();
    applyCheck(16'h1234, 16'h0F0F, 4'b0000, 1'b0, {1'b0, 16'h1234}, "R2 transfer");
    applyCheck(16'hFFFF, 16'h0000, 4'b0000, 1'b1, {1'b1, 16'h0000}, "R4 inc wrap");
    applyCheck(16'hFFFF, 16'h0001, 4'b0001, 1'b0, {1'b1, 16'h0000}, "R4 add carry");
    applyCheck(16'h8000, 16'h8000, 4'b0001, 1'b1, {1'b1, 16'h0001}, "R2 add plus one");
    applyCheck(16'h5555, 16'h5555, 4'b0010, 1'b1, {1'b1, 16'h0000}, "R4 sub equal");
    applyCheck(16'h0003, 16'h0005, 4'b0010, 1'b1, {1'b0, 16'hFFFE}, "R3 sub negative");
    applyCheck(16'h0007, 16'h0002, 4'b0010, 1'b0, {1'b1, 16'h0004}, "R3 sub borrow");
    applyCheck(16'h0000, 16'h1111, 4'b0011, 1'b0, {1'b0, 16'hFFFF}, "R3 dec zero");
    applyCheck(16'h0000, 16'h1111, 4'b0011, 1'b1, {1'b1, 16'h0000}, "R3 code111 transfer");
    applyCheck(16'hABCD, 16'h1111, 4'b0011, 1'b1, {1'b1, 16'hABCD}, "R3 code111 transfer");
  endtask

  task automatic testNoCarryLeak();
    for (int s = 4; s < 16; s++) begin
      applyCheck('1, '1, 4'(s), 1'b1, refModel('1, '1, 4'(s), 1'b0), "R8 no carry");
    end
  endtask

  task automatic testLogicCinIgnored();
    for (int s = 0; s < 4; s++) begin
      applyCheck(16'hC3A5, 16'h0FF0, 4'(4 + s), 1'b0,
                 refModel(16'hC3A5, 16'h0FF0, 4'(4 + s), 1'b0), "R5 cin0");
      applyCheck(16'hC3A5, 16'h0FF0, 4'(4 + s), 1'b1,
                 refModel(16'hC3A5, 16'h0FF0, 4'(4 + s), 1'b0), "R5 cin1");
    end
  endtask

  task automatic testShifts();
    for (int low = 0; low < 4; low++) begin
      applyCheck(16'h8001, 16'hFFFF, 4'(8 + low), 1'b1, {1'b0, 16'h4000}, "R6 shr fill R1");
      applyCheck(16'h8001, 16'hFFFF, 4'(12 + low), 1'b1, {1'b0, 16'h0002}, "R7 shl fill R1");
    end
    applyCheck(16'hFFFF, 16'h0000, 4'b1000, 1'b0, {1'b0, 16'h7FFF}, "R6 shr ones");
    applyCheck(16'hFFFF, 16'h0000, 4'b1100, 1'b0, {1'b0, 16'hFFFE}, "R7 shl ones");
  endtask

  initial begin
    opA = '0; opB = '0; sel = '0; carryIn = 1'b0;
    testIdle();
    testArithEdges();
    testLogicCinIgnored();
    testShifts();
    testNoCarryLeak();
    testSweep();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule